// File: doc/BRIEF.md
# Priority Interrupt Arbiter with Vectoring

This block keeps the pending interrupt requests of a processor, organised as a number of priority levels, each with one request line per source. It compares the pending set against the processor's current priority and drives one combinational "interrupt pending" flag. When the processor strobes acknowledge, the arbiter picks the winning request, clears it in the same clock edge, and presents the vector of that source one cycle later.

Each source has a vector held in a table that software-side logic loads through a write port. A source may instead be marked dynamic. Its vector is then taken from an input supplied by the device during an acknowledge handshake. Reset seeds the entries of the programmed (software-triggered) requests, one per level from 1 upward, all with one shared vector.

A bus-type input picks full-priority mode or single-level mode. In single-level mode device sources all behave as if they sat at one low level. Once the current priority reaches a threshold, only sources marked internal in a per-level mask stay eligible.

Top module: `irq_vec_arbiter`

## Requirements
- R1: `irq_pend` is 1 exactly when some pending request sits at a level strictly above `cur_ipl` and is eligible. Level 0 is never eligible, and neither is any level at or below `cur_ipl`.
- R2: With `bus_single`=1 and `cur_ipl` >= 4, only the internal sources are eligible. In the default mask these are source indices 30 and 31 of every level. With `bus_single`=0, or with `cur_ipl` < 4, every source is eligible.
- R3: The winner is the eligible request at the highest level. Within that level, the lowest source index wins.
- R4: An `ack` that finds an eligible request clears that request at the clock edge. On the next cycle `vec_valid` is 1 and `vec_out` holds the winner's vector. `vec_valid` is 1 exactly in the cycle after each `ack` cycle, and `vec_out` holds its value until the next `ack`.
- R5: An `ack` with no eligible request returns `vec_out`=0 and clears nothing.
- R6: A table write (`tbl_we`) stores `tbl_vec` and the dynamic flag `tbl_dyn` for the addressed level and source. If the winner is marked dynamic, `dyn_take` is 1 during the `ack` cycle, `dyn_lvl`/`dyn_idx` name the source, and the returned vector is `dyn_vec` as sampled in that cycle.
- R7: After reset no request is pending, `vec_out`=0 and `vec_valid`=0. For levels 1 to 7, the table entry at source index 31 holds vector 0x0A0 and is not dynamic. All other entries hold 0 and are not dynamic.
- R8: A set of a request bit wins over a clear of the same bit in the same cycle, whether the clear comes from the clear port or from an acknowledge grant.
- R9: `irq_pend` follows `cur_ipl` and `bus_single` combinationally, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_single | input | 1 | 1 = single-level bus mode, 0 = full-priority mode |
| cur_ipl | input | 3 | Current processor priority level |
| set_vld | input | 1 | Set strobe for one request bit |
| set_lvl | input | 3 | Level of the bit to set |
| set_idx | input | 5 | Source index of the bit to set |
| clr_vld | input | 1 | Clear strobe for one request bit |
| clr_lvl | input | 3 | Level of the bit to clear |
| clr_idx | input | 5 | Source index of the bit to clear |
| tbl_we | input | 1 | Vector table write enable |
| tbl_lvl | input | 3 | Table entry level |
| tbl_idx | input | 5 | Table entry source index |
| tbl_vec | input | 9 | Vector to store |
| tbl_dyn | input | 1 | Dynamic-vector flag to store |
| ack | input | 1 | Acknowledge strobe |
| dyn_vec | input | 9 | Vector supplied by a dynamic source during ack |
| irq_pend | output | 1 | An eligible request is pending |
| dyn_take | output | 1 | Ack is granting a dynamic source |
| dyn_lvl | output | 3 | Level of the current winner |
| dyn_idx | output | 5 | Source index of the current winner |
| vec_out | output | 9 | Vector of the last acknowledge |
| vec_valid | output | 1 | Pulse: vec_out was just updated by an ack |

## Verification
The bench sweeps every priority, every level and both bus modes, using source indices on each side of the internal mask. A design with an off-by-one at the priority compare, or with the mask applied below the threshold, raises the flag for the wrong cases. Draining a multi-level request set by repeated acknowledges shows whether the level scan and the in-level order are reversed, and whether a granted bit is left set. A final acknowledge on an empty set must return 0. Set/clear collisions, dynamic sources and the seeded programmed-interrupt vectors each get a directed case. A design that lets clear win the collision, or that reads the table for a dynamic source, returns the wrong pending state or the wrong vector.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int DEF_LEVELS   = 8;
    localparam int DEF_SOURCES  = 32;
    localparam int DEF_VEC_W    = 9;
    localparam int DEF_THRESH   = 4;
    localparam int DEF_SOFT_VEC = 'h0A0;

    typedef enum logic {
        BUS_FULL   = 1'b0,
        BUS_SINGLE = 1'b1
    } bus_mode_e;

    // True when device sources must be filtered through the internal mask
    function automatic logic mask_active(input bus_mode_e mode, input int ipl, input int thresh);
        return (mode == BUS_SINGLE) && (ipl >= thresh);
    endfunction

endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
    parameter int LEVELS  = 8,
    parameter int SOURCES = 32,
    localparam int LW = $clog2(LEVELS),
    localparam int SW = $clog2(SOURCES)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              set_vld,
    input  logic [LW-1:0]                     set_lvl,
    input  logic [SW-1:0]                     set_idx,
    input  logic                              clr_vld,
    input  logic [LW-1:0]                     clr_lvl,
    input  logic [SW-1:0]                     clr_idx,
    input  logic                              grant_clr,
    input  logic [LW-1:0]                     grant_lvl,
    input  logic [SW-1:0]                     grant_idx,
    output logic [LEVELS-1:0][SOURCES-1:0]    req_q
);

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        for (genvar s = 0; s < SOURCES; s++) begin : g_src
            logic hit_set, hit_clr;
            assign hit_set = set_vld && (set_lvl == LW'(l)) && (set_idx == SW'(s));
            assign hit_clr = (clr_vld && (clr_lvl == LW'(l)) && (clr_idx == SW'(s)))
                          || (grant_clr && (grant_lvl == LW'(l)) && (grant_idx == SW'(s)));
            always_ff @(posedge clk) begin
                if (rst)          req_q[l][s] <= 1'b0;
                else if (hit_set) req_q[l][s] <= 1'b1;
                else if (hit_clr) req_q[l][s] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_arb_pkg::*;
#(
    parameter int LEVELS  = 8,
    parameter int SOURCES = 32,
    parameter int THRESH  = 4,
    parameter logic [LEVELS-1:0][SOURCES-1:0] INT_MASK = '0,
    localparam int LW = $clog2(LEVELS),
    localparam int SW = $clog2(SOURCES)
) (
    input  logic [LEVELS-1:0][SOURCES-1:0] req_q,
    input  logic [LW-1:0]                  cur_ipl,
    input  bus_mode_e                      mode,
    output logic                           hit,
    output logic [LW-1:0]                  win_lvl,
    output logic [SW-1:0]                  win_idx
);

    logic                               filt;
    logic [LEVELS-1:0][SOURCES-1:0]     elig;

    assign filt = mask_active(mode, int'(cur_ipl), THRESH);

    for (genvar l = 0; l < LEVELS; l++) begin : g_elig
        logic above;
        assign above   = (l > int'(cur_ipl));
        assign elig[l] = above ? (filt ? (req_q[l] & INT_MASK[l]) : req_q[l]) : '0;
    end

    always_comb begin
        hit     = 1'b0;
        win_lvl = '0;
        win_idx = '0;
        // ascending scan: a later (higher) level overwrites an earlier one
        for (int l = 0; l < LEVELS; l++) begin
            if (|elig[l]) begin
                hit     = 1'b1;
                win_lvl = LW'(l);
                // descending scan: the lowest set index is written last
                for (int s = SOURCES - 1; s >= 0; s--) begin
                    if (elig[l][s]) win_idx = SW'(s);
                end
            end
        end
    end

endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
    parameter int LEVELS   = 8,
    parameter int SOURCES  = 32,
    parameter int VEC_W    = 9,
    parameter int SOFT_IDX = 31,
    parameter int SOFT_VEC = 'h0A0,
    localparam int LW = $clog2(LEVELS),
    localparam int SW = $clog2(SOURCES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [LW-1:0]    wr_lvl,
    input  logic [SW-1:0]    wr_idx,
    input  logic [VEC_W-1:0] wr_vec,
    input  logic             wr_dyn,
    input  logic [LW-1:0]    rd_lvl,
    input  logic [SW-1:0]    rd_idx,
    output logic [VEC_W-1:0] rd_vec,
    output logic             rd_dyn
);

    logic [VEC_W-1:0] vec_mem [LEVELS][SOURCES];
    logic             dyn_mem [LEVELS][SOURCES];

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        for (genvar s = 0; s < SOURCES; s++) begin : g_src
            localparam logic [VEC_W-1:0] SEED =
                ((l >= 1) && (s == SOFT_IDX)) ? VEC_W'(SOFT_VEC) : '0;
            logic sel;
            assign sel = we && (wr_lvl == LW'(l)) && (wr_idx == SW'(s));
            always_ff @(posedge clk) begin
                if (rst) begin
                    vec_mem[l][s] <= SEED;
                    dyn_mem[l][s] <= 1'b0;
                end else if (sel) begin
                    vec_mem[l][s] <= wr_vec;
                    dyn_mem[l][s] <= wr_dyn;
                end
            end
        end
    end

    assign rd_vec = vec_mem[rd_lvl][rd_idx];
    assign rd_dyn = dyn_mem[rd_lvl][rd_idx];

endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter
    import irq_arb_pkg::*;
#(
    parameter int LEVELS   = DEF_LEVELS,
    parameter int SOURCES  = DEF_SOURCES,
    parameter int VEC_W    = DEF_VEC_W,
    parameter int THRESH   = DEF_THRESH,
    parameter int SOFT_IDX = SOURCES - 1,
    parameter int SOFT_VEC = DEF_SOFT_VEC,
    parameter logic [LEVELS-1:0][SOURCES-1:0] INT_MASK =
        {LEVELS{ {2'b11, {(SOURCES-2){1'b0}}} }},
    localparam int LW = $clog2(LEVELS),
    localparam int SW = $clog2(SOURCES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_single,
    input  logic [LW-1:0]    cur_ipl,
    input  logic             set_vld,
    input  logic [LW-1:0]    set_lvl,
    input  logic [SW-1:0]    set_idx,
    input  logic             clr_vld,
    input  logic [LW-1:0]    clr_lvl,
    input  logic [SW-1:0]    clr_idx,
    input  logic             tbl_we,
    input  logic [LW-1:0]    tbl_lvl,
    input  logic [SW-1:0]    tbl_idx,
    input  logic [VEC_W-1:0] tbl_vec,
    input  logic             tbl_dyn,
    input  logic             ack,
    input  logic [VEC_W-1:0] dyn_vec,
    output logic             irq_pend,
    output logic             dyn_take,
    output logic [LW-1:0]    dyn_lvl,
    output logic [SW-1:0]    dyn_idx,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid
);

    logic [LEVELS-1:0][SOURCES-1:0] req_q;
    logic                           hit;
    logic [LW-1:0]                  win_lvl;
    logic [SW-1:0]                  win_idx;
    logic                           grant;
    logic [VEC_W-1:0]               tbl_rd_vec;
    logic                           tbl_rd_dyn;
    logic [VEC_W-1:0]               vec_nxt;
    bus_mode_e                      mode;

    assign mode  = bus_mode_e'(bus_single);
    assign grant = ack && hit;

    irq_req_bank #(.LEVELS(LEVELS), .SOURCES(SOURCES)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .set_vld   (set_vld),
        .set_lvl   (set_lvl),
        .set_idx   (set_idx),
        .clr_vld   (clr_vld),
        .clr_lvl   (clr_lvl),
        .clr_idx   (clr_idx),
        .grant_clr (grant),
        .grant_lvl (win_lvl),
        .grant_idx (win_idx),
        .req_q     (req_q)
    );

    irq_pick #(.LEVELS(LEVELS), .SOURCES(SOURCES), .THRESH(THRESH),
               .INT_MASK(INT_MASK)) u_pick (
        .req_q   (req_q),
        .cur_ipl (cur_ipl),
        .mode    (mode),
        .hit     (hit),
        .win_lvl (win_lvl),
        .win_idx (win_idx)
    );

    irq_vec_table #(.LEVELS(LEVELS), .SOURCES(SOURCES), .VEC_W(VEC_W),
                    .SOFT_IDX(SOFT_IDX), .SOFT_VEC(SOFT_VEC)) u_tbl (
        .clk    (clk),
        .rst    (rst),
        .we     (tbl_we),
        .wr_lvl (tbl_lvl),
        .wr_idx (tbl_idx),
        .wr_vec (tbl_vec),
        .wr_dyn (tbl_dyn),
        .rd_lvl (win_lvl),
        .rd_idx (win_idx),
        .rd_vec (tbl_rd_vec),
        .rd_dyn (tbl_rd_dyn)
    );

    assign irq_pend = hit;
    assign dyn_take = grant && tbl_rd_dyn;
    assign dyn_lvl  = win_lvl;
    assign dyn_idx  = win_idx;

    always_comb begin
        if (!hit)            vec_nxt = '0;
        else if (tbl_rd_dyn) vec_nxt = dyn_vec;
        else                 vec_nxt = tbl_rd_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_out   <= '0;
            vec_valid <= 1'b0;
        end else begin
            vec_valid <= ack;
            if (ack) vec_out <= vec_nxt;
        end
    end

endmodule

// File: rtl/irq_vec_arbiter_chk.sv
module irq_vec_arbiter_chk #(
    parameter int LEVELS  = 8,
    parameter int SOURCES = 32,
    parameter int VEC_W   = 9,
    parameter int THRESH  = 4,
    parameter logic [LEVELS-1:0][SOURCES-1:0] INT_MASK = '0,
    localparam int LW = $clog2(LEVELS),
    localparam int SW = $clog2(SOURCES)
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           bus_single,
    input logic [LW-1:0]                  cur_ipl,
    input logic                           set_vld,
    input logic [LW-1:0]                  set_lvl,
    input logic [SW-1:0]                  set_idx,
    input logic                           ack,
    input logic                           irq_pend,
    input logic                           dyn_take,
    input logic [LW-1:0]                  dyn_lvl,
    input logic [SW-1:0]                  dyn_idx,
    input logic [VEC_W-1:0]               vec_out,
    input logic                           vec_valid,
    input logic [LEVELS-1:0][SOURCES-1:0] req_q
);

    // R1
    top_ipl_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_ipl == LW'(LEVELS-1)) |-> !irq_pend);

    // R2
    single_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_single && (int'(cur_ipl) >= THRESH) && ((req_q & INT_MASK) == '0)) |-> !irq_pend);

    // R4
    ack_valid_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> vec_valid);

    // R4
    idle_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !ack |=> !vec_valid);

    // R4
    grant_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && irq_pend && !(set_vld && set_lvl == dyn_lvl && set_idx == dyn_idx))
        |=> !req_q[$past(dyn_lvl)][$past(dyn_idx)]);

    // R5
    empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !irq_pend) |=> (vec_out == '0));

    // R6
    dyn_take_chk: assert property (@(posedge clk) disable iff (rst)
        dyn_take |-> (ack && irq_pend));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_vld |=> req_q[$past(set_lvl)][$past(set_idx)]);

endmodule

bind irq_vec_arbiter irq_vec_arbiter_chk #(
    .LEVELS(LEVELS), .SOURCES(SOURCES), .VEC_W(VEC_W), .THRESH(THRESH), .INT_MASK(INT_MASK)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_single (bus_single),
    .cur_ipl    (cur_ipl),
    .set_vld    (set_vld),
    .set_lvl    (set_lvl),
    .set_idx    (set_idx),
    .ack        (ack),
    .irq_pend   (irq_pend),
    .dyn_take   (dyn_take),
    .dyn_lvl    (dyn_lvl),
    .dyn_idx    (dyn_idx),
    .vec_out    (vec_out),
    .vec_valid  (vec_valid),
    .req_q      (req_q)
);

// File: tb/irq_vec_arbiter_bench.sv
module irq_vec_arbiter_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_single;
    logic [2:0] cur_ipl;
    logic       set_vld, clr_vld, tbl_we, tbl_dyn, ack;
    logic [2:0] set_lvl, clr_lvl, tbl_lvl;
    logic [4:0] set_idx, clr_idx, tbl_idx;
    logic [8:0] tbl_vec, dyn_vec;
    logic       irq_pend, dyn_take, vec_valid;
    logic [2:0] dyn_lvl;
    logic [4:0] dyn_idx;
    logic [8:0] vec_out;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    bit       mreq [8][32];
    bit [8:0] mvec [8][32];
    bit       mdyn [8][32];

    always #4 clk = ~clk;

    irq_vec_arbiter u_irq_vec_arbiter (
        .clk(clk), .rst(rst), .bus_single(bus_single), .cur_ipl(cur_ipl),
        .set_vld(set_vld), .set_lvl(set_lvl), .set_idx(set_idx),
        .clr_vld(clr_vld), .clr_lvl(clr_lvl), .clr_idx(clr_idx),
        .tbl_we(tbl_we), .tbl_lvl(tbl_lvl), .tbl_idx(tbl_idx),
        .tbl_vec(tbl_vec), .tbl_dyn(tbl_dyn), .ack(ack), .dyn_vec(dyn_vec),
        .irq_pend(irq_pend), .dyn_take(dyn_take), .dyn_lvl(dyn_lvl),
        .dyn_idx(dyn_idx), .vec_out(vec_out), .vec_valid(vec_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic bit eligible(input bit mode, input int ipl, input int l, input int i);
        if (l <= ipl) return 0;
        if (mode && ipl >= 4) return (i >= 30);
        return 1;
    endfunction

    task automatic model_reset();
        for (int l = 0; l < 8; l++)
            for (int i = 0; i < 32; i++) begin
                mreq[l][i] = 0;
                mdyn[l][i] = 0;
                mvec[l][i] = (l >= 1 && i == 31) ? 9'h0A0 : 9'h000;
            end
    endtask

    task automatic exp_win(output bit h, output int wl, output int wi);
        h = 0; wl = 0; wi = 0;
        for (int l = 7; l >= 0; l--)
            for (int i = 0; i < 32; i++)
                if (!h && mreq[l][i] && eligible(bus_single, int'(cur_ipl), l, i)) begin
                    h = 1; wl = l; wi = i;
                end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
    endtask

    task automatic set_req(input int l, input int i);
        @(negedge clk);
        set_vld = 1; set_lvl = 3'(l); set_idx = 5'(i);
        @(negedge clk);
        set_vld = 0;
        mreq[l][i] = 1;
    endtask

    task automatic clr_req(input int l, input int i);
        @(negedge clk);
        clr_vld = 1; clr_lvl = 3'(l); clr_idx = 5'(i);
        @(negedge clk);
        clr_vld = 0;
        mreq[l][i] = 0;
    endtask

    task automatic wr_tbl(input int l, input int i, input int v, input bit d);
        @(negedge clk);
        tbl_we = 1; tbl_lvl = 3'(l); tbl_idx = 5'(i); tbl_vec = 9'(v); tbl_dyn = d;
        @(negedge clk);
        tbl_we = 0;
        mvec[l][i] = 9'(v);
        mdyn[l][i] = d;
    endtask

    // one acknowledge, result compared against the model
    task automatic do_ack(input string req);
        bit h; int wl, wi; bit [8:0] ev;
        @(negedge clk);
        exp_win(h, wl, wi);
        ev = h ? (mdyn[wl][wi] ? dyn_vec : mvec[wl][wi]) : 9'h000;
        ack = 1;
        @(negedge clk);
        ack = 0;
        if (h) mreq[wl][wi] = 0;
        chk(vec_valid == 1'b1, req, int'(vec_valid), 1);
        chk(vec_out == ev, req, int'(vec_out), int'(ev));
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int idx_list [5] = '{0, 7, 29, 30, 31};
        rst = 1; bus_single = 0; cur_ipl = 0;
        set_vld = 0; clr_vld = 0; tbl_we = 0; ack = 0;
        set_lvl = 0; set_idx = 0; clr_lvl = 0; clr_idx = 0;
        tbl_lvl = 0; tbl_idx = 0; tbl_vec = 0; tbl_dyn = 0; dyn_vec = 0;
        do_reset();

        // R7 reset state
        chk(irq_pend == 1'b0, "R7", int'(irq_pend), 0);
        chk(vec_out == 9'h0, "R7", int'(vec_out), 0);
        chk(vec_valid == 1'b0, "R7", int'(vec_valid), 0);

        // R7 seeded programmed-interrupt vector, and an unseeded entry
        set_req(3, 31);
        do_ack("R7");
        set_req(4, 5);
        do_ack("R7");
        // R5 empty acknowledge
        do_ack("R5");

        // R1 R2 sweep over mode, priority, level and source
        for (int m = 0; m < 2; m++)
            for (int p = 0; p < 8; p++)
                for (int l = 0; l < 8; l++)
                    for (int k = 0; k < 5; k++) begin
                        bus_single = m[0];
                        cur_ipl = 3'(p);
                        set_req(l, idx_list[k]);
                        chk(irq_pend == eligible(m[0], p, l, idx_list[k]),
                            (m == 0) ? "R1" : "R2", int'(irq_pend),
                            int'(eligible(m[0], p, l, idx_list[k])));
                        clr_req(l, idx_list[k]);
                        chk(irq_pend == 1'b0, "R1", int'(irq_pend), 0);
                    end

        // R9 priority and mode changes take effect without a clock edge
        bus_single = 0; cur_ipl = 0;
        set_req(5, 3);
        @(negedge clk);
        #1 cur_ipl = 5;
        #1 chk(irq_pend == 1'b0, "R9", int'(irq_pend), 0);
        cur_ipl = 4;
        #1 chk(irq_pend == 1'b1, "R9", int'(irq_pend), 1);
        bus_single = 1;
        #1 chk(irq_pend == 1'b0, "R9", int'(irq_pend), 0);
        bus_single = 0;
        clr_req(5, 3);

        // R3 R4 load distinct vectors, fill several levels, drain by ack
        for (int l = 1; l < 8; l++)
            for (int k = 0; k < 5; k++)
                wr_tbl(l, idx_list[k], l * 32 + idx_list[k] + 1, 0);
        foreach (idx_list[k]) begin
            set_req(2, idx_list[k]);
            set_req(5, idx_list[k]);
            set_req(6, idx_list[k]);
        end
        set_req(1, 7);
        cur_ipl = 1; bus_single = 0;
        for (int n = 0; n < 15; n++) do_ack("R3");
        chk(irq_pend == 1'b0, "R4", int'(irq_pend), 0);
        do_ack("R5");
        cur_ipl = 0;
        do_ack("R3");
        do_ack("R5");

        // R2 R3 single-level mode at threshold: device bit at higher level masked
        bus_single = 1; cur_ipl = 4;
        set_req(5, 0); set_req(5, 30); set_req(6, 3);
        chk(irq_pend == 1'b1, "R2", int'(irq_pend), 1);
        do_ack("R2");
        chk(irq_pend == 1'b0, "R2", int'(irq_pend), 0);
        bus_single = 0;
        do_ack("R3");
        do_ack("R3");

        // R6 dynamic vector source
        cur_ipl = 0;
        wr_tbl(6, 2, 'h011, 1);
        set_req(6, 2);
        dyn_vec = 9'h155;
        @(negedge clk);
        ack = 1;
        #1 chk(dyn_take == 1'b1, "R6", int'(dyn_take), 1);
        chk(dyn_lvl == 3'd6, "R6", int'(dyn_lvl), 6);
        chk(dyn_idx == 5'd2, "R6", int'(dyn_idx), 2);
        @(negedge clk);
        ack = 0;
        mreq[6][2] = 0;
        chk(vec_out == 9'h155, "R6", int'(vec_out), 'h155);
        chk(dyn_take == 1'b0, "R6", int'(dyn_take), 0);

        // R8 set and clear of one bit in the same cycle
        @(negedge clk);
        set_vld = 1; set_lvl = 3; set_idx = 9;
        clr_vld = 1; clr_lvl = 3; clr_idx = 9;
        @(negedge clk);
        set_vld = 0; clr_vld = 0;
        mreq[3][9] = 1;
        chk(irq_pend == 1'b1, "R8", int'(irq_pend), 1);
        // R8 set while the same bit is granted by ack
        @(negedge clk);
        ack = 1; set_vld = 1; set_lvl = 3; set_idx = 9;
        @(negedge clk);
        ack = 0; set_vld = 0;
        chk(irq_pend == 1'b1, "R8", int'(irq_pend), 1);
        chk(vec_out == 9'h000, "R8", int'(vec_out), 0);
        do_ack("R8");
        chk(irq_pend == 1'b0, "R8", int'(irq_pend), 0);

        // R7 reset clears requests and restores seeded entries
        set_req(7, 31);
        wr_tbl(2, 31, 'h033, 0);
        do_reset();
        chk(irq_pend == 1'b0, "R7", int'(irq_pend), 0);
        set_req(2, 31);
        do_ack("R7");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule